// File: doc/BRIEF.md
# Backplane Bus Slave with Byte Lane Steering

This block is the slave end of an asynchronous backplane bus with 20 address lines and 16 data lines. A bus master raises one of four active-high command lines (memory read, memory write, I/O read, I/O write) together with an address, a byte-high-enable and write data, and holds them until the slave answers. The slave checks whether the address falls inside its memory window (for memory commands) or its I/O register window (for I/O commands). On a hit it performs the access on local storage after a configurable number of wait cycles and then raises a transfer acknowledge. The master ends the cycle by withdrawing the command. The length of a bus cycle is therefore set by the slave, not by a fixed count.

A single byte always travels on data lines 7..0. An odd-address byte is swapped between the low lane and the high half of the stored word, in both directions. An inhibit input lets an overlaid ROM own the shared address range. While inhibit is high, this RAM slave stays silent.

Flow control is the command/acknowledge pair. The master may not change address or data while a command is high. The slave owns the data lanes only while it acknowledges a read. A command that the slave declines is never acknowledged, and the slave ignores it until the master withdraws it.

Top module: `xbs_slave`

## Requirements
- R1: After reset, `xack` and `rdata_oe` are low and `rdata` is zero.
- R2: An accepted command is acknowledged exactly LATENCY+2 clock edges after the first edge that sees it. `xack` then stays high while the command is held, and falls at the first edge after the command is withdrawn.
- R3: With address bit 0 = 0 and `bhe` = 1, a memory access moves the whole 16-bit word at (address − MEM_BASE)/2. The low byte is on data bits 7..0 and the high byte is on bits 15..8.
- R4: With address bit 0 = 0 and `bhe` = 0, only the low byte of the word is touched. A read returns it on bits 7..0 with bits 15..8 zero. A write takes bits 7..0 and leaves the high byte unchanged.
- R5: With address bit 0 = 1, whatever `bhe` is, only the high byte of the word is touched, and it is carried on bits 7..0. A read returns it there with bits 15..8 zero. A write stores bits 7..0 into the high byte, ignores bits 15..8 of the bus, and leaves the low byte unchanged.
- R6: I/O commands reach a separate register window at IO_BASE and leave memory untouched. Memory commands that address the I/O window are not acknowledged.
- R7: A command whose address lies outside its window (at or beyond base + 2·words) is never acknowledged and writes nothing.
- R8: A command that begins while `inhibit` is high is never acknowledged and writes nothing, even if `inhibit` falls before the command is withdrawn.
- R9: More than one command line high at once is never acknowledged and has no effect.
- R10: `rdata_oe` is high only while a read is being acknowledged. It is low during a write acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 20 | Bus address from the master |
| wdata | input | 16 | Write data from the master |
| bhe | input | 1 | Byte-high-enable from the master |
| cmd_mrd | input | 1 | Memory read command |
| cmd_mwr | input | 1 | Memory write command |
| cmd_iord | input | 1 | I/O read command |
| cmd_iowr | input | 1 | I/O write command |
| inhibit | input | 1 | Overlay inhibit; the slave stays silent while high |
| rdata | output | 16 | Read data, zero unless driving |
| rdata_oe | output | 1 | Slave is driving the data lanes |
| xack | output | 1 | Transfer acknowledge |

## Verification
The bench builds the slave with a 16-word memory window at 0x40000, a 4-word I/O window at 0x00100 and a latency of 3.

These values are small enough to sweep every memory word through word, low-byte and odd-byte reads and writes. The expected contents of each word are computed in a bench model. The windows also put both boundaries, the first word past the memory window and the I/O range, within a few cycles' reach. The latency of 3 makes the acknowledge arrive at a distinctive edge count, so an off-by-one in the wait-state counter is caught on every cycle.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  localparam int unsigned BUS_AW = 20;
  localparam int unsigned BUS_DW = 16;
  localparam int unsigned LANES  = BUS_DW / 8;

  typedef enum logic [1:0] {
    LANE_WORD,
    LANE_LOW,
    LANE_ODD
  } lane_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_ACCESS,
    ST_ACK,
    ST_MISS
  } state_e;

  function automatic int unsigned idx_width(int unsigned words);
    return (words > 1) ? $clog2(words) : 1;
  endfunction
endpackage

// File: rtl/xbs_decode.sv
module xbs_decode
  import xbs_pkg::*;
#(
  parameter logic [BUS_AW-1:0] MEM_BASE  = 20'h10000,
  parameter int unsigned       MEM_WORDS = 1024,
  parameter logic [BUS_AW-1:0] IO_BASE   = 20'h00300,
  parameter int unsigned       IO_WORDS  = 8,
  parameter int unsigned       MAW       = 10,
  parameter int unsigned       IAW       = 3
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic              bhe,
  input  logic              is_io,
  output logic              hit,
  output logic [MAW-1:0]    mem_idx,
  output logic [IAW-1:0]    io_idx,
  output lane_e             lane
);
  localparam logic [BUS_AW-1:0] MEM_SPAN = BUS_AW'(2 * MEM_WORDS);
  localparam logic [BUS_AW-1:0] IO_SPAN  = BUS_AW'(2 * IO_WORDS);

  logic [BUS_AW-1:0] mem_off, io_off;
  logic              mem_in, io_in;

  always_comb begin
    mem_off = addr - MEM_BASE;
    io_off  = addr - IO_BASE;
    mem_in  = (addr >= MEM_BASE) && (mem_off < MEM_SPAN);
    io_in   = (addr >= IO_BASE) && (io_off < IO_SPAN);
    hit     = is_io ? io_in : mem_in;
    mem_idx = mem_off[MAW:1];
    io_idx  = io_off[IAW:1];
    if (addr[0])  lane = LANE_ODD;
    else if (bhe) lane = LANE_WORD;
    else          lane = LANE_LOW;
  end
endmodule

// File: rtl/xbs_swap.sv
module xbs_swap
  import xbs_pkg::*;
(
  input  lane_e             lane,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic [BUS_DW-1:0] stored,
  output logic [LANES-1:0]  be,
  output logic [BUS_DW-1:0] wword,
  output logic [BUS_DW-1:0] bus_rdata
);
  always_comb begin
    unique case (lane)
      LANE_LOW: begin
        be        = 2'b01;
        wword     = {bus_wdata[7:0], bus_wdata[7:0]};
        bus_rdata = {8'h00, stored[7:0]};
      end
      LANE_ODD: begin
        be        = 2'b10;
        wword     = {bus_wdata[7:0], bus_wdata[7:0]};
        bus_rdata = {8'h00, stored[15:8]};
      end
      default: begin
        be        = 2'b11;
        wword     = bus_wdata;
        bus_rdata = stored;
      end
    endcase
  end

  always_comb begin
    if (lane != LANE_WORD)
      assert_byte_single_lane_R5: assert ($countones(be) == 1);
  end
endmodule

// File: rtl/xbs_store.sv
module xbs_store
  import xbs_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [AW-1:0]     idx,
  input  logic [BUS_DW-1:0] wword,
  output logic [BUS_DW-1:0] rword
);
  logic [BUS_DW-1:0] arr [DEPTH];
  logic [BUS_DW-1:0] merged;

  assign rword = arr[idx];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = be[g] ? wword[g*8 +: 8] : rword[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (we) arr[idx] <= merged;
  end
endmodule

// File: rtl/xbs_slave.sv
module xbs_slave
  import xbs_pkg::*;
#(
  parameter logic [BUS_AW-1:0] MEM_BASE  = 20'h10000,
  parameter int unsigned       MEM_WORDS = 1024,
  parameter logic [BUS_AW-1:0] IO_BASE   = 20'h00300,
  parameter int unsigned       IO_WORDS  = 8,
  parameter int unsigned       LATENCY   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] addr,
  input  logic [BUS_DW-1:0] wdata,
  input  logic              bhe,
  input  logic              cmd_mrd,
  input  logic              cmd_mwr,
  input  logic              cmd_iord,
  input  logic              cmd_iowr,
  input  logic              inhibit,
  output logic [BUS_DW-1:0] rdata,
  output logic              rdata_oe,
  output logic              xack
);
  localparam int unsigned MAW = idx_width(MEM_WORDS);
  localparam int unsigned IAW = idx_width(IO_WORDS);
  localparam int unsigned CW  = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  state_e            state;
  logic [3:0]        cmd_vec;
  logic              cmd_any;
  logic [BUS_AW-1:0] lat_addr;
  logic [BUS_DW-1:0] lat_wdata;
  logic              lat_bhe, lat_io, lat_wr;
  logic [CW-1:0]     cnt;
  logic [BUS_DW-1:0] rd_q;

  logic              hit;
  logic [MAW-1:0]    mem_idx;
  logic [IAW-1:0]    io_idx;
  lane_e             lane;
  logic [LANES-1:0]  be;
  logic [BUS_DW-1:0] wword, stored, mem_word, io_word, rbus;
  logic              finish, mem_we, io_we;

  assign cmd_vec = {cmd_iowr, cmd_iord, cmd_mwr, cmd_mrd};
  assign cmd_any = |cmd_vec;

  xbs_decode #(
    .MEM_BASE(MEM_BASE), .MEM_WORDS(MEM_WORDS),
    .IO_BASE(IO_BASE), .IO_WORDS(IO_WORDS),
    .MAW(MAW), .IAW(IAW)
  ) u_decode (
    .addr(lat_addr), .bhe(lat_bhe), .is_io(lat_io),
    .hit(hit), .mem_idx(mem_idx), .io_idx(io_idx), .lane(lane)
  );

  assign stored = lat_io ? io_word : mem_word;

  xbs_swap u_swap (
    .lane(lane), .bus_wdata(lat_wdata), .stored(stored),
    .be(be), .wword(wword), .bus_rdata(rbus)
  );

  assign finish = (state == ST_ACCESS) && (cnt == '0);
  assign mem_we = finish && lat_wr && !lat_io;
  assign io_we  = finish && lat_wr && lat_io;

  xbs_store #(.DEPTH(MEM_WORDS), .AW(MAW)) u_mem (
    .clk(clk), .we(mem_we), .be(be), .idx(mem_idx),
    .wword(wword), .rword(mem_word)
  );

  xbs_store #(.DEPTH(IO_WORDS), .AW(IAW)) u_io (
    .clk(clk), .we(io_we), .be(be), .idx(io_idx),
    .wword(wword), .rword(io_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_bhe   <= 1'b0;
      lat_io    <= 1'b0;
      lat_wr    <= 1'b0;
      cnt       <= '0;
      rd_q      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd_any) begin
            if (inhibit || !$onehot(cmd_vec)) begin
              state <= ST_MISS;
            end else begin
              state     <= ST_DECODE;
              lat_addr  <= addr;
              lat_wdata <= wdata;
              lat_bhe   <= bhe;
              lat_io    <= cmd_iord | cmd_iowr;
              lat_wr    <= cmd_mwr | cmd_iowr;
            end
          end
        end
        ST_DECODE: begin
          if (hit) begin
            state <= ST_ACCESS;
            cnt   <= CW'(LATENCY - 1);
          end else begin
            state <= ST_MISS;
          end
        end
        ST_ACCESS: begin
          if (cnt == '0) begin
            state <= ST_ACK;
            rd_q  <= lat_wr ? '0 : rbus;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACK: begin
          if (!cmd_any) begin
            state <= ST_IDLE;
            rd_q  <= '0;
          end
        end
        ST_MISS: begin
          if (!cmd_any) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign xack     = (state == ST_ACK);
  assign rdata_oe = (state == ST_ACK) && !lat_wr;
  assign rdata    = rdata_oe ? rd_q : '0;

  assert_ack_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xack && !cmd_any) |=> !xack);
  assert_ack_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xack && cmd_any) |=> xack);
  assert_wait_states_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACCESS && cnt != '0) |=> (state == ST_ACCESS));
  assert_inhibit_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && inhibit) |=> (state != ST_DECODE));
  assert_multi_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $countones(cmd_vec) > 1) |=> (state != ST_DECODE));
  assert_oe_with_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (xack && (cmd_mrd || cmd_iord || !cmd_any)));
endmodule

// File: tb/test_xbs_slave.sv
`timescale 1ns/1ps
module test_xbs_slave;
  localparam logic [19:0] MB = 20'h40000;
  localparam int          MW = 16;
  localparam logic [19:0] IB = 20'h00100;
  localparam int          IW = 4;
  localparam int          LT = 3;
  localparam logic [3:0]  C_MRD = 4'b0001, C_MWR = 4'b0010,
                          C_IORD = 4'b0100, C_IOWR = 4'b1000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        bhe = 1'b0, inhibit = 1'b0;
  logic        cmd_mrd = 1'b0, cmd_mwr = 1'b0, cmd_iord = 1'b0, cmd_iowr = 1'b0;
  logic [15:0] rdata;
  logic        rdata_oe, xack;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  logic [15:0] mem_model [MW];
  logic [15:0] io_model [IW];

  always #2 clk = ~clk;

  xbs_slave #(.MEM_BASE(MB), .MEM_WORDS(MW), .IO_BASE(IB), .IO_WORDS(IW),
              .LATENCY(LT)) i_xbs_slave (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .bhe(bhe),
    .cmd_mrd(cmd_mrd), .cmd_mwr(cmd_mwr), .cmd_iord(cmd_iord),
    .cmd_iowr(cmd_iowr), .inhibit(inhibit), .rdata(rdata),
    .rdata_oe(rdata_oe), .xack(xack));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cmd(input logic [3:0] c);
    {cmd_iowr, cmd_iord, cmd_mwr, cmd_mrd} = c;
  endtask

  // Full handshake; checks R2 latency and release, R10 output enable.
  task automatic cycle(input string req, input logic [3:0] c, input logic [19:0] a,
                       input logic hi, input logic [15:0] wd, output logic [15:0] rd);
    int n = 0;
    logic oe;
    addr = a; bhe = hi; wdata = wd; set_cmd(c);
    rd = '0; oe = 1'b0;
    while (!xack && n < LT + 20) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk({req, " R2 latency"}, 16'(n), 16'(LT + 2));
    rd = rdata; oe = rdata_oe;
    chk({req, " R10 oe"}, 16'(oe), 16'((c == C_MRD) || (c == C_IORD)));
    @(posedge clk); @(negedge clk);
    chk({req, " R2 ack held"}, 16'(xack), 16'd1);
    set_cmd(4'b0000);
    @(posedge clk); @(negedge clk);
    chk({req, " R2 ack release"}, 16'(xack), 16'd0);
  endtask

  task automatic no_ack(input string req, input logic [3:0] c, input logic [19:0] a,
                        input logic [15:0] wd, input bit drop_inh);
    int seen = 0;
    addr = a; bhe = 1'b1; wdata = wd; set_cmd(c);
    for (int k = 0; k < LT + 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (xack) seen++;
      if (drop_inh && k == 1) inhibit = 1'b0;
    end
    chk({req, " no ack"}, 16'(seen), 16'd0);
    set_cmd(4'b0000);
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [15:0] pat(int i);
    return {8'(i * 37 + 5), 8'(i * 11 + 200)};
  endfunction

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    chk("R1 xack", 16'(xack), 16'd0);
    chk("R1 oe", 16'(rdata_oe), 16'd0);
    chk("R1 rdata", rdata, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < MW; i++) begin
      logic [19:0] a;
      logic [7:0]  b1, b2;
      a = MB + 20'(2 * i);
      mem_model[i] = pat(i);
      cycle("R3 wr", C_MWR, a, 1'b1, pat(i), r);
      cycle("R3 rd", C_MRD, a, 1'b1, 16'h0, r);
      chk("R3 word read", r, mem_model[i]);
      cycle("R4 rd", C_MRD, a, 1'b0, 16'h0, r);
      chk("R4 low byte read", r, {8'h00, mem_model[i][7:0]});
      cycle("R5 rd", C_MRD, a + 20'd1, 1'b1, 16'h0, r);
      chk("R5 odd byte read", r, {8'h00, mem_model[i][15:8]});
      b1 = 8'(i ^ 8'h5A);
      b2 = 8'(i * 3 + 1);
      cycle("R4 wr", C_MWR, a, 1'b0, {8'hEE, b1}, r);
      mem_model[i][7:0] = b1;
      cycle("R5 wr", C_MWR, a + 20'd1, 1'b1, {8'hCC, b2}, r);
      mem_model[i][15:8] = b2;
      cycle("R4R5 rd", C_MRD, a, 1'b1, 16'h0, r);
      chk("R4 R5 merged word", r, mem_model[i]);
    end

    cycle("R5 rd bhe0", C_MRD, MB + 20'd3, 1'b0, 16'h0, r);
    chk("R5 odd byte with bhe low", r, {8'h00, mem_model[1][15:8]});

    for (int j = 0; j < IW; j++) begin
      io_model[j] = 16'(16'hB00 + j * 16'h0111);
      cycle("R6 io wr", C_IOWR, IB + 20'(2 * j), 1'b1, io_model[j], r);
    end
    for (int j = 0; j < IW; j++) begin
      cycle("R6 io rd", C_IORD, IB + 20'(2 * j), 1'b1, 16'h0, r);
      chk("R6 io read", r, io_model[j]);
    end
    cycle("R6 mem after io", C_MRD, MB, 1'b1, 16'h0, r);
    chk("R6 memory untouched by io", r, mem_model[0]);
    no_ack("R6 mem cmd in io window", C_MRD, IB, 16'h0, 1'b0);
    no_ack("R6 io cmd in mem window", C_IORD, MB, 16'h0, 1'b0);

    no_ack("R7 past end", C_MWR, MB + 20'(2 * MW), 16'hDEAD, 1'b0);
    no_ack("R7 below base", C_MWR, MB - 20'd2, 16'hDEAD, 1'b0);
    no_ack("R7 io past end", C_IOWR, IB + 20'(2 * IW), 16'hDEAD, 1'b0);
    cycle("R7 last word", C_MRD, MB + 20'(2 * (MW - 1)), 1'b1, 16'h0, r);
    chk("R7 last word intact", r, mem_model[MW - 1]);

    inhibit = 1'b1;
    no_ack("R8 inhibit", C_MWR, MB, 16'h1234, 1'b1);
    chk("R8 inhibit released", 16'(inhibit), 16'd0);
    cycle("R8 rd", C_MRD, MB, 1'b1, 16'h0, r);
    chk("R8 word unchanged", r, mem_model[0]);

    no_ack("R9 two cmds", C_MRD | C_MWR, MB + 20'd2, 16'h4321, 1'b0);
    cycle("R9 rd", C_MRD, MB + 20'd2, 1'b1, 16'h0, r);
    chk("R9 word unchanged", r, mem_model[1]);
    chk("R1 idle rdata zero", rdata, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL R2 watchdog actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule